// File: doc/BRIEF.md
# Temperature Event Output Logic

This block receives temperature samples from a converter. It compares each new sample against three programmable limits: high, low and critical. It keeps one status flag for each limit, with a selectable hysteresis band that acts only as the temperature falls. From those flags it derives one event condition and drives it onto an open-drain style pin model.

The event can work in three ways:
- **Comparator mode.** The event follows the flags and releases by itself.
- **Interrupt mode.** The event is latched until software clears it.
- **Critical-only.** Only the critical flag can raise the event.

The critical flag always acts as a comparator, whichever mode is selected. An enable, a polarity select and a shutdown input complete the configuration. Register storage, the serial interface and the converter are outside this block.

Top module: `tevent_logic`

## Requirements
- R1: After reset all three flags and `evt_status` are 0. With `polarity`=0 the pin is released (`evt_pull_en`=0, `evt_level`=1).
- R2: Limits are signed 11-bit values in 0.25 °C steps. Comparisons use only `sample[12:2]`, so `sample[1:0]` has no effect on any output.
- R3: `flag_hi` sets when the sample is greater than `lim_hi`. Once set, it clears only when the sample is at or below `lim_hi` minus the hysteresis. The hysteresis for `hyst_code` 0, 1, 2, 3 is 0, 6, 12 and 24 quarter-degrees (0, 1.5, 3 and 6 °C).
- R4: `flag_crit` behaves like `flag_hi` but against `lim_crit`. No flag changes in a cycle without an accepted sample.
- R5: `flag_lo` sets when the sample is less than `lim_lo` minus the hysteresis. Once set, it clears when the sample is greater than or equal to `lim_lo`.
- R6: With `int_mode`=0 (comparator), the event is active whenever `flag_hi` or `flag_lo` is set and releases by itself when both clear. `clr_evt` has no effect in this mode.
- R7: With `int_mode`=1 (interrupt), a rising edge of `flag_hi` or `flag_lo` latches the event. The event stays active until `clr_evt` is 1 for one cycle. A flag that simply stays set does not latch the event again after a clear.
- R8: A set `flag_crit` makes the event active in either mode, and the event releases when `flag_crit` clears. With `crit_only`=1 the high and low flags never make the event active.
- R9: With `evt_en`=0 the event is never active.
- R10: `evt_status` is 1 exactly when the event is active, whatever the polarity. `evt_level` equals `evt_status` when `polarity`=1 and its inverse when `polarity`=0. `evt_pull_en` is the inverse of `evt_level`.
- R11: While `shutdown`=1 the event is inactive and samples are ignored, so the flags hold. After `shutdown` returns to 0 the event stays inactive until the next accepted sample, and any latched interrupt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 13 | Signed temperature sample, 0.0625 °C per LSB |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| lim_hi | input | 11 | High limit, signed, 0.25 °C per LSB |
| lim_lo | input | 11 | Low limit, signed, 0.25 °C per LSB |
| lim_crit | input | 11 | Critical limit, signed, 0.25 °C per LSB |
| hyst_code | input | 2 | Hysteresis select: 0, 1.5, 3 or 6 °C |
| shutdown | input | 1 | Converter shut down |
| evt_en | input | 1 | Event enable |
| crit_only | input | 1 | Only the critical flag drives the event |
| polarity | input | 1 | 1 means the active event is a high level |
| int_mode | input | 1 | 1 selects interrupt, 0 selects comparator |
| clr_evt | input | 1 | One-cycle pulse that clears a latched interrupt |
| flag_hi | output | 1 | Above the high limit |
| flag_lo | output | 1 | Below the low limit |
| flag_crit | output | 1 | Above the critical limit |
| evt_status | output | 1 | Event active, independent of polarity |
| evt_pull_en | output | 1 | Pin pull-down enable |
| evt_level | output | 1 | Logic level on the pin |

## Verification
The assertions assume that `sample_vld` and `clr_evt` are held low during reset. They also assume that the limits and configuration are stable in any cycle whose result they check.

The stimulus draws every limit from a band of a few hundred quarter-degrees. Samples are drawn within forty quarter-degrees of the limits, so the hysteresis subtraction stays inside the widened comparison range. Shutdown is raised rarely and for short stretches, so that the hold-off after exit is reached often. Configuration changes are made only at the falling clock edge.

// File: rtl/tevent_logic.sv
module tevent_logic #(
  parameter int TW   = 13,
  parameter int HYS1 = 6,
  parameter int HYS2 = 12,
  parameter int HYS3 = 24,
  localparam int QW  = TW - 2,
  localparam int EW  = QW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sample,
  input  logic          sample_vld,
  input  logic [QW-1:0] lim_hi,
  input  logic [QW-1:0] lim_lo,
  input  logic [QW-1:0] lim_crit,
  input  logic [1:0]    hyst_code,
  input  logic          shutdown,
  input  logic          evt_en,
  input  logic          crit_only,
  input  logic          polarity,
  input  logic          int_mode,
  input  logic          clr_evt,
  output logic          flag_hi,
  output logic          flag_lo,
  output logic          flag_crit,
  output logic          evt_status,
  output logic          evt_pull_en,
  output logic          evt_level
);

  logic signed [EW-1:0] t_q, hi_q, lo_q, cr_q, hq;
  logic nxt_hi, nxt_lo, nxt_cr, take, rise;
  logic latch_q, hold_q;

  assign t_q  = EW'($signed(sample[TW-1:2]));
  assign hi_q = EW'($signed(lim_hi));
  assign lo_q = EW'($signed(lim_lo));
  assign cr_q = EW'($signed(lim_crit));

  always_comb begin
    case (hyst_code)
      2'd1:    hq = EW'(HYS1);
      2'd2:    hq = EW'(HYS2);
      2'd3:    hq = EW'(HYS3);
      default: hq = '0;
    endcase
  end

  assign nxt_hi = flag_hi   ? (t_q > hi_q - hq) : (t_q > hi_q);
  assign nxt_cr = flag_crit ? (t_q > cr_q - hq) : (t_q > cr_q);
  assign nxt_lo = flag_lo   ? (t_q < lo_q)      : (t_q < lo_q - hq);

  assign take = sample_vld & ~shutdown;
  assign rise = (nxt_hi & ~flag_hi) | (nxt_lo & ~flag_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
      flag_crit <= 1'b0;
      latch_q   <= 1'b0;
      hold_q    <= 1'b0;
    end else if (shutdown) begin
      latch_q <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      latch_q <= (latch_q & ~(clr_evt & int_mode)) |
                 (take & rise & int_mode & evt_en & ~crit_only);
      if (take) begin
        flag_hi   <= nxt_hi;
        flag_lo   <= nxt_lo;
        flag_crit <= nxt_cr;
        hold_q    <= 1'b0;
      end
    end
  end

  logic hl_evt;
  assign hl_evt      = ~crit_only & (int_mode ? latch_q : (flag_hi | flag_lo));
  assign evt_status  = evt_en & ~shutdown & ~hold_q & (flag_crit | hl_evt);
  assign evt_level   = polarity ? evt_status : ~evt_status;
  assign evt_pull_en = ~evt_level;

endmodule

module tevent_logic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] sample,
  input logic        sample_vld,
  input logic [10:0] lim_hi,
  input logic [10:0] lim_lo,
  input logic        shutdown,
  input logic        evt_en,
  input logic        flag_hi,
  input logic        flag_lo,
  input logic        flag_crit,
  input logic        evt_status
);

  a_r3_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !shutdown && !flag_hi && ($signed(sample[12:2]) > $signed(lim_hi)))
    |=> flag_hi);

  a_r5_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !shutdown && flag_lo && ($signed(sample[12:2]) >= $signed(lim_lo)))
    |=> !flag_lo);

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_vld && !shutdown) |=> ($stable(flag_hi) && $stable(flag_lo) && $stable(flag_crit)));

  a_r9_no_event_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |-> !evt_status);

  a_r11_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !evt_status);

  a_r8_crit_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sample_vld && !shutdown) && flag_crit && evt_en && !shutdown) |-> evt_status);

endmodule

bind tevent_logic tevent_logic_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .sample_vld(sample_vld),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .shutdown(shutdown), .evt_en(evt_en),
  .flag_hi(flag_hi), .flag_lo(flag_lo), .flag_crit(flag_crit),
  .evt_status(evt_status)
);

// File: tb/test_tevent_logic.sv
`timescale 1ns/1ps
module test_tevent_logic;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] sample = '0;
  logic sample_vld = 1'b0;
  logic [10:0] lim_hi = '0, lim_lo = '0, lim_crit = '0;
  logic [1:0] hyst_code = '0;
  logic shutdown = 0, evt_en = 0, crit_only = 0, polarity = 0, int_mode = 0, clr_evt = 0;
  logic flag_hi, flag_lo, flag_crit, evt_status, evt_pull_en, evt_level;

  always #2.5 clk = ~clk;

  tevent_logic i_tevent_logic (
    .clk(clk), .rst_n(rst_n), .sample(sample), .sample_vld(sample_vld),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst_code(hyst_code),
    .shutdown(shutdown), .evt_en(evt_en), .crit_only(crit_only), .polarity(polarity),
    .int_mode(int_mode), .clr_evt(clr_evt), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .flag_crit(flag_crit), .evt_status(evt_status), .evt_pull_en(evt_pull_en),
    .evt_level(evt_level)
  );

  int checks = 0;
  int errors = 0;
  bit m_hi, m_lo, m_cr, m_latch, m_hold;

  function automatic int hyst_q(logic [1:0] c);
    case (c)
      2'd1: return 6;
      2'd2: return 12;
      2'd3: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int sx(logic [10:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [12:0] mk(int q);
    logic [10:0] t;
    t = q[10:0];
    return {t, 2'($urandom_range(0, 3))};
  endfunction

  task automatic model_update();
    int t, h;
    bit nh, nl, nc, rise;
    t = sx(sample[12:2]);
    h = hyst_q(hyst_code);
    if (shutdown) begin
      m_latch = 0;
      m_hold = 1;
    end else begin
      nh = m_hi ? (t > sx(lim_hi) - h) : (t > sx(lim_hi));
      nc = m_cr ? (t > sx(lim_crit) - h) : (t > sx(lim_crit));
      nl = m_lo ? (t < sx(lim_lo)) : (t < sx(lim_lo) - h);
      rise = (nh && !m_hi) || (nl && !m_lo);
      m_latch = (m_latch && !(clr_evt && int_mode)) ||
                (sample_vld && rise && int_mode && evt_en && !crit_only);
      if (sample_vld) begin
        m_hi = nh; m_lo = nl; m_cr = nc; m_hold = 0;
      end
    end
  endtask

  task automatic check_all(string req);
    bit act;
    logic [5:0] exp_v, got_v;
    act = evt_en && !shutdown && !m_hold &&
          (m_cr || (!crit_only && (int_mode ? m_latch : (m_hi || m_lo))));
    exp_v = {m_hi, m_lo, m_cr, act, !(polarity ? act : !act), polarity ? act : !act};
    got_v = {flag_hi, flag_lo, flag_crit, evt_status, evt_pull_en, evt_level};
    checks++;
    if (got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got %b expected %b (hi lo crit status pull level)", req, got_v, exp_v);
    end
  endtask

  task automatic step(string req);
    model_update();
    @(negedge clk);
    sample_vld = 0;
    clr_evt = 0;
    check_all(req);
  endtask

  task automatic put(int q, string req);
    sample = mk(q);
    sample_vld = 1;
    step(req);
  endtask

  task automatic expect_bit(string req, logic got, logic exp_b);
    checks++;
    if (got !== exp_b) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp_b);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    expect_bit("R1 pin released", evt_pull_en, 1'b0);

    lim_hi = 11'd100; lim_lo = 11'd40; lim_crit = 11'd160;
    evt_en = 1; hyst_code = 2'd1;
    sample = {11'd100, 2'b11}; sample_vld = 1; step("R2 fraction ignored");
    expect_bit("R2 hi stays clear", flag_hi, 1'b0);
    put(101, "R3 hi sets");
    expect_bit("R3 hi set", flag_hi, 1'b1);
    expect_bit("R6 comparator event", evt_status, 1'b1);
    put(95, "R3 inside band");
    expect_bit("R3 hi held", flag_hi, 1'b1);
    clr_evt = 1; step("R6 clear ignored");
    expect_bit("R6 clear ignored", evt_status, 1'b1);
    put(94, "R3 hi clears");
    expect_bit("R3 hi clear", flag_hi, 1'b0);
    expect_bit("R6 self release", evt_status, 1'b0);

    hyst_code = 2'd3;
    put(35, "R5 within band");
    expect_bit("R5 lo not set", flag_lo, 1'b0);
    put(15, "R5 below band");
    expect_bit("R5 lo set", flag_lo, 1'b1);
    put(39, "R5 still low");
    put(40, "R5 lo clears");
    expect_bit("R5 lo clear", flag_lo, 1'b0);

    int_mode = 1; hyst_code = 2'd2;
    put(120, "R7 latch");
    expect_bit("R7 latched", evt_status, 1'b1);
    put(70, "R7 held after return");
    expect_bit("R7 held", evt_status, 1'b1);
    put(120, "R7 second rise");
    clr_evt = 1; step("R7 clear");
    expect_bit("R7 cleared", evt_status, 1'b0);
    put(125, "R7 persist no relatch");
    expect_bit("R7 no relatch", evt_status, 1'b0);

    put(170, "R8 crit");
    expect_bit("R8 crit in int mode", evt_status, 1'b1);
    put(150, "R8 crit band");
    put(148, "R8 crit clears");
    expect_bit("R8 crit released", evt_status, 1'b0);
    crit_only = 1; int_mode = 0;
    put(50, "R8 reset hi");
    put(130, "R8 crit only hi");
    expect_bit("R8 crit only suppresses", evt_status, 1'b0);
    crit_only = 0; @(negedge clk); check_all("R6 comparator resume");
    evt_en = 0; @(negedge clk); check_all("R9 disabled");
    expect_bit("R9 disabled", evt_status, 1'b0);
    evt_en = 1; polarity = 1; @(negedge clk); check_all("R10 high polarity");
    expect_bit("R10 level high", evt_level, 1'b1);

    shutdown = 1; step("R11 shutdown");
    put(60, "R11 sample ignored");
    expect_bit("R11 hi held", flag_hi, 1'b1);
    shutdown = 0; step("R11 hold after exit");
    expect_bit("R11 still quiet", evt_status, 1'b0);
    put(130, "R11 release on sample");
    expect_bit("R11 event back", evt_status, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      int base;
      if ($urandom_range(0, 99) < 3) begin
        lim_lo = 11'($urandom_range(0, 200) - 100);
        lim_hi = 11'(sx(lim_lo) + $urandom_range(20, 150));
        lim_crit = 11'(sx(lim_hi) + $urandom_range(0, 150));
      end
      if ($urandom_range(0, 99) < 5) begin
        hyst_code = 2'($urandom_range(0, 3));
        evt_en = ($urandom_range(0, 9) != 0);
        crit_only = ($urandom_range(0, 5) == 0);
        polarity = 1'($urandom_range(0, 1));
        int_mode = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 99) < 2) shutdown = ~shutdown;
      clr_evt = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 2))
        0: base = sx(lim_lo);
        1: base = sx(lim_hi);
        default: base = sx(lim_crit);
      endcase
      sample = mk(base + $urandom_range(0, 80) - 40);
      sample_vld = ($urandom_range(0, 3) != 0);
      step("R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule